// File: doc/BRIEF.md
# Layered Min-Sum LDPC Decoder with Per-Edge Scaling

The block decodes one short quasi-cyclic LDPC codeword at a time. A start pulse loads a block of signed fixed-point channel log-likelihood ratios, one per code bit. A bit that was not transmitted (punctured) arrives as a zero. The core then runs min-sum message passing on a layered schedule: one check row per clock cycle, with posterior values updated in place. Every message that leaves a check node is scaled by a factor of its own, taken from a parameter table indexed by edge.

After each full pass over the check rows, the core takes the sign of every posterior as a hard decision and evaluates all parity checks on those bits. It stops as soon as every check is satisfied, or when an iteration ceiling is reached. At the end it presents the hard-decision word, a flag that tells whether the checks were satisfied, and the number of iterations used. The base matrix shifts, the lifting size, the message width, the scale table and the iteration ceiling are all parameters. The default code has a 2x4 base matrix lifted by 4, which gives 16 code bits and 8 checks.

Top module: `ldpc_nms_decoder`

## Requirements
- R1: While reset is high and in the cycle after it, `busy`, `done`, `converged`, `iters` and `hard_out` are all zero.
- R2: Bit v of `hard_out` is 1 exactly when the final posterior of bit v is negative; a posterior of zero gives 0. With all scale factors zero, the posteriors equal the input LLRs, so a zero input LLR yields 0.
- R3: Check m = r*Z + i (r = base row, i in 0..Z-1) connects bit c*Z + ((i + S[r][c]) mod Z) for every base column c. The default shifts are S[0] = {0,1,2,3} and S[1] = {0,2,3,1} for c = 0..3. `converged` is 1 only if the hard-decision word satisfies every such check.
- R4: The message from a check to a bit is the minimum magnitude among the other bits of that check. Its sign is the product of those other bits' signs. It is multiplied by that edge's 4-bit factor in units of 1/8, truncated toward zero and saturated to the message range.
- R5: Posterior and extrinsic sums saturate at ±(2^(QW-1)-1) and never wrap. An all-ones codeword whose LLRs are all at -127 decodes to all ones.
- R6: If the checks are satisfied after iteration k, decoding stops with `converged` = 1 and `iters` = k. A valid codeword with correct-sign LLRs gives k = 1. A single weak bit in error among strong bits is corrected in one iteration.
- R7: If the checks are still unsatisfied after MAX_ITER iterations, decoding stops with `converged` = 0 and `iters` = MAX_ITER.
- R8: `done` is a one-cycle pulse that comes exactly k*(M+1) clock cycles after the edge that accepted `start`, where M is the number of checks and k = `iters`. `busy` falls on that same edge.
- R9: A `start` pulse while `busy` is high is ignored. The result and the timing follow the block that was first accepted.
- R10: A punctured bit (input LLR 0) whose checks each have every other bit reliable is restored to its codeword value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load `llr_in` and begin decoding when idle |
| llr_in | input | N*QW | Signed LLR of bit v in bits [v*QW +: QW]; positive favours 0 |
| busy | output | 1 | High while a block is being decoded |
| done | output | 1 | One-cycle pulse when results are valid |
| hard_out | output | N | Hard-decision word, bit v for code bit v |
| converged | output | 1 | All parity checks satisfied at the end |
| iters | output | IW | Number of iterations performed |

## Verification
The checker assumes that the environment never asserts reset in the middle of a block without then waiting for the idle state. It also assumes that `start` is a single-cycle pulse. The bench drives `start` for exactly one cycle and holds `llr_in` steady around the accepting edge. The only deliberate violation is a start pulse during decoding, which the block has to drop. Expected words are codewords formed from whole circulant columns, so they are valid for any shift choice. The bench works out convergence for non-codewords from its own parity function, built from the connection rule. It uses a second instance with all scale factors zero, whose posteriors never move, to reach the iteration ceiling.

// File: rtl/ldpc_pkg.sv
package ldpc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_CHK} dec_state_t;

  // bit index reached by base column c from check row i of a circulant with shift sh
  function automatic int bit_of(input int i, input int c, input int z, input int sh);
    return c * z + ((i + sh) % z);
  endfunction
endpackage

// File: rtl/ldpc_cnu.sv
module ldpc_cnu
  import ldpc_pkg::*;
#(
  parameter int QW = 8,
  parameter int DC = 4,
  parameter int AW = 4,
  parameter int AF = 3
) (
  input  logic signed [QW-1:0] post_i  [DC],
  input  logic signed [QW-1:0] msg_i   [DC],
  input  logic        [AW-1:0] alpha_i [DC],
  output logic signed [QW-1:0] post_o  [DC],
  output logic signed [QW-1:0] msg_o   [DC]
);
  localparam int QMAX = 2 ** (QW - 1) - 1;
  localparam int MW = QW - 1;

  function automatic logic signed [QW-1:0] clampq(input logic signed [QW:0] x);
    if (x > QMAX) return QW'(QMAX);
    if (x < -QMAX) return QW'(-QMAX);
    return x[QW-1:0];
  endfunction

  logic signed [QW-1:0] q   [DC];
  logic        [MW-1:0] mag [DC];
  logic        [MW-1:0] min1, min2;
  int                   idx1;
  logic                 par;

  always_comb begin
    min1 = MW'(QMAX);
    min2 = MW'(QMAX);
    idx1 = 0;
    par  = 1'b0;
    for (int c = 0; c < DC; c++) begin
      q[c]   = clampq({post_i[c][QW-1], post_i[c]} - {msg_i[c][QW-1], msg_i[c]});
      mag[c] = q[c][QW-1] ? MW'(-q[c]) : MW'(q[c]);
      par    = par ^ q[c][QW-1];
      if (mag[c] < min1) begin
        min2 = min1;
        min1 = mag[c];
        idx1 = c;
      end else if (mag[c] < min2) begin
        min2 = mag[c];
      end
    end
  end

  for (genvar c = 0; c < DC; c++) begin : g_edge
    logic [MW-1:0]        sel;
    logic [MW+AW-1:0]     prod;
    logic [MW+AW-1:0]     shr;
    logic [MW-1:0]        scaled;
    logic signed [QW-1:0] rv;
    always_comb begin
      sel    = (idx1 == c) ? min2 : min1;
      prod   = (MW+AW)'(sel) * (MW+AW)'(alpha_i[c]);
      shr    = prod >> AF;
      scaled = (shr > (MW+AW)'(QMAX)) ? MW'(QMAX) : shr[MW-1:0];
      rv     = (par ^ q[c][QW-1]) ? -$signed({1'b0, scaled}) : $signed({1'b0, scaled});
      msg_o[c]  = rv;
      post_o[c] = clampq({q[c][QW-1], q[c]} + {rv[QW-1], rv});
    end
  end
endmodule

// File: rtl/ldpc_syndrome.sv
module ldpc_syndrome
  import ldpc_pkg::*;
#(
  parameter int BR = 2,
  parameter int BC = 4,
  parameter int Z  = 4,
  parameter logic [8*BR*BC-1:0] SHIFT = '0
) (
  input  logic [BC*Z-1:0] hd_i,
  output logic            ok_o
);
  localparam int M = BR * Z;
  logic [M-1:0] odd;

  for (genvar m = 0; m < M; m++) begin : g_chk
    always_comb begin
      odd[m] = 1'b0;
      for (int c = 0; c < BC; c++)
        odd[m] = odd[m] ^ hd_i[bit_of(m % Z, c, Z, int'(SHIFT[8*((m / Z)*BC + c) +: 8]))];
    end
  end

  assign ok_o = (odd == '0);
endmodule

// File: rtl/ldpc_nms_decoder.sv
module ldpc_nms_decoder
  import ldpc_pkg::*;
#(
  parameter int BR = 2,
  parameter int BC = 4,
  parameter int Z  = 4,
  parameter int QW = 8,
  parameter int AW = 4,
  parameter int AF = 3,
  parameter int MAX_ITER = 10,
  parameter logic [8*BR*BC-1:0] SHIFT = {8'd1, 8'd3, 8'd2, 8'd0, 8'd3, 8'd2, 8'd1, 8'd0},
  parameter logic [AW*BR*Z*BC-1:0] ALPHA = {(BR*Z*BC/4){16'h7645}},
  localparam int N  = BC * Z,
  localparam int IW = $clog2(MAX_ITER + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [N*QW-1:0] llr_in,
  output logic            busy,
  output logic            done,
  output logic [N-1:0]    hard_out,
  output logic            converged,
  output logic [IW-1:0]   iters
);
  localparam int M    = BR * Z;
  localparam int LW   = (M > 1) ? $clog2(M) : 1;
  localparam int QMAX = 2 ** (QW - 1) - 1;

  dec_state_t           state;
  logic [LW-1:0]        layer;
  logic [IW-1:0]        iter;
  logic signed [QW-1:0] post [N];
  logic signed [QW-1:0] rmem [M][BC];

  int                   vidx    [BC];
  logic signed [QW-1:0] post_in [BC];
  logic signed [QW-1:0] msg_in  [BC];
  logic        [AW-1:0] alpha_in[BC];
  logic signed [QW-1:0] post_new[BC];
  logic signed [QW-1:0] msg_new [BC];
  logic [N-1:0]         hd;
  logic                 syn_ok;
  logic [IW-1:0]        iter_n;

  always_comb begin
    for (int c = 0; c < BC; c++) begin
      vidx[c]     = bit_of(int'(layer) % Z, c, Z,
                           int'(SHIFT[8*((int'(layer) / Z)*BC + c) +: 8]));
      post_in[c]  = post[vidx[c]];
      msg_in[c]   = (iter == '0) ? '0 : rmem[layer][c];
      alpha_in[c] = ALPHA[AW*(int'(layer)*BC + c) +: AW];
    end
    for (int v = 0; v < N; v++) hd[v] = post[v][QW-1];
  end

  assign iter_n = iter + 1'b1;

  ldpc_cnu #(.QW(QW), .DC(BC), .AW(AW), .AF(AF)) u_cnu (
    .post_i(post_in), .msg_i(msg_in), .alpha_i(alpha_in),
    .post_o(post_new), .msg_o(msg_new)
  );

  ldpc_syndrome #(.BR(BR), .BC(BC), .Z(Z), .SHIFT(SHIFT)) u_syn (
    .hd_i(hd), .ok_o(syn_ok)
  );

  // extrinsic message store: one word per check row, no reset
  always_ff @(posedge clk) begin
    if (state == ST_RUN)
      for (int c = 0; c < BC; c++) rmem[layer][c] <= msg_new[c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      layer     <= '0;
      iter      <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      hard_out  <= '0;
      converged <= 1'b0;
      iters     <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          for (int v = 0; v < N; v++)
            post[v] <= ($signed(llr_in[v*QW +: QW]) < -QMAX) ? QW'(-QMAX) : llr_in[v*QW +: QW];
          layer <= '0;
          iter  <= '0;
          busy  <= 1'b1;
          state <= ST_RUN;
        end
        ST_RUN: begin
          for (int c = 0; c < BC; c++) post[vidx[c]] <= post_new[c];
          if (int'(layer) == M - 1) state <= ST_CHK;
          else layer <= layer + 1'b1;
        end
        ST_CHK: begin
          if (syn_ok || iter_n == IW'(MAX_ITER)) begin
            hard_out  <= hd;
            converged <= syn_ok;
            iters     <= iter_n;
            done      <= 1'b1;
            busy      <= 1'b0;
            state     <= ST_IDLE;
          end else begin
            iter  <= iter_n;
            layer <= '0;
            state <= ST_RUN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldpc_nms_chk.sv
module ldpc_nms_chk #(
  parameter int MAX_ITER = 10,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          converged,
  input logic [IW-1:0] iters
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!busy && !done && !converged && iters == '0));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R6
  iter_range_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (iters >= IW'(1) && iters <= IW'(MAX_ITER)));

  // R7
  iter_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !converged) |-> iters == IW'(MAX_ITER));

  // R9
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
endmodule

bind ldpc_nms_decoder ldpc_nms_chk #(.MAX_ITER(MAX_ITER), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .converged(converged), .iters(iters)
);

// File: tb/ldpc_nms_decoder_tb.sv
module ldpc_nms_decoder_tb;
  localparam int CLK_P = 10;
  localparam int N = 16;
  localparam int QW = 8;
  localparam int M = 8;
  localparam int MAXI = 10;
  localparam int NONE = 31;

  typedef struct packed {
    logic [15:0]       cw;
    logic [7:0]        mag;
    logic [4:0]        ep;
    logic signed [7:0] ev;
    logic [4:0]        pp;
  } vec_t;

  // codewords are unions of whole circulant columns (even count), valid for any shifts
  localparam vec_t VECS [9] = '{
    '{16'h0000, 8'd20,  5'd31, 8'sd0,  5'd31},  // R6 all-zero
    '{16'hFFFF, 8'd20,  5'd31, 8'sd0,  5'd31},  // R6 all-one
    '{16'h00FF, 8'd30,  5'd31, 8'sd0,  5'd31},  // R6 columns 0,1
    '{16'h0000, 8'd20,  5'd5,  -8'sd5, 5'd31},  // R4/R6 weak error
    '{16'hFFFF, 8'd20,  5'd10, 8'sd5,  5'd31},  // R4/R6 weak error
    '{16'hFF00, 8'd40,  5'd31, 8'sd0,  5'd12},  // R10 punctured one
    '{16'hFFFF, 8'd127, 5'd31, 8'sd0,  5'd31},  // R5 saturation
    '{16'h0F0F, 8'd25,  5'd31, 8'sd0,  5'd3},   // R10 punctured one
    '{16'h0000, 8'd1,   5'd31, 8'sd0,  5'd31}   // R6 minimal magnitude
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic st_a = 1'b0, st_z = 1'b0;
  logic [N*QW-1:0] llr = '0;
  logic busy_a, done_a, conv_a, busy_z, done_z, conv_z;
  logic [N-1:0] hard_a, hard_z;
  logic [3:0] it_a, it_z;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ldpc_nms_decoder u_dut (
    .clk(clk), .rst(rst), .start(st_a), .llr_in(llr), .busy(busy_a), .done(done_a),
    .hard_out(hard_a), .converged(conv_a), .iters(it_a)
  );

  ldpc_nms_decoder #(.ALPHA('0)) u_dut_zero (
    .clk(clk), .rst(rst), .start(st_z), .llr_in(llr), .busy(busy_z), .done(done_z),
    .hard_out(hard_z), .converged(conv_z), .iters(it_z)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [N*QW-1:0] mk(input vec_t t);
    logic [N*QW-1:0] l;
    for (int v = 0; v < N; v++) begin
      logic signed [7:0] x;
      x = t.cw[v] ? -$signed(t.mag) : $signed(t.mag);
      if (v == int'(t.ep)) x = t.ev;
      if (v == int'(t.pp)) x = 8'sd0;
      l[v*QW +: QW] = x;
    end
    return l;
  endfunction

  // parity of pattern under the connection rule of R3
  function automatic bit satisfies(input logic [N-1:0] p);
    int sh [2][4] = '{'{0, 1, 2, 3}, '{0, 2, 3, 1}};
    for (int m = 0; m < M; m++) begin
      bit x = 1'b0;
      for (int c = 0; c < 4; c++) x ^= p[c*4 + ((m % 4 + sh[m/4][c]) % 4)];
      if (x) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic run(input bit zsel, input logic [N*QW-1:0] l, output logic [N-1:0] h,
                     output logic c, output int it, output int cyc);
    @(negedge clk);
    llr = l;
    if (zsel) st_z = 1'b1; else st_a = 1'b1;
    @(negedge clk);
    st_a = 1'b0; st_z = 1'b0; cyc = 0;
    while (!(zsel ? done_z : done_a) && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    h  = zsel ? hard_z : hard_a;
    c  = zsel ? conv_z : conv_a;
    it = int'(zsel ? it_z : it_a);
    @(negedge clk);
    check("R8 done pulse width", 32'(zsel ? done_z : done_a), 32'd0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] h;
    logic c;
    int it, cyc;
    repeat (3) @(negedge clk);
    check("R1 busy", 32'(busy_a), 0);
    check("R1 done", 32'(done_a), 0);
    check("R1 hard", 32'(hard_a), 0);
    check("R1 converged", 32'(conv_a), 0);
    check("R1 iters", 32'(it_a), 0);
    rst = 1'b0;

    for (int k = 0; k < 9; k++) begin
      run(1'b0, mk(VECS[k]), h, c, it, cyc);
      check($sformatf("R6 vec%0d hard", k), 32'(h), 32'(VECS[k].cw));
      check($sformatf("R6 vec%0d converged", k), 32'(c), 1);
      check($sformatf("R6 vec%0d iters", k), 32'(it), 1);
      check($sformatf("R8 vec%0d latency", k), 32'(cyc), 32'(M + 1));
    end

    // R7 / R2: zero scaling, weak error at bit 5, punctured bit 9
    run(1'b1, mk('{16'h0000, 8'd20, 5'd5, -8'sd5, 5'd9}), h, c, it, cyc);
    check("R2 zero llr and sign decision", 32'(h), 32'h0020);
    check("R7 not converged", 32'(c), 0);
    check("R7 iters at ceiling", 32'(it), MAXI);
    check("R8 latency at ceiling", 32'(cyc), 32'(MAXI * (M + 1)));

    // R3: non-codeword patterns judged by the connection rule
    foreach (VECS[k]) begin end
    for (int p = 0; p < 3; p++) begin
      logic [15:0] pat;
      pat = (p == 0) ? 16'h0021 : (p == 1) ? 16'h0041 : 16'h0F0F;
      run(1'b1, mk('{pat, 8'd20, 5'd31, 8'sd0, 5'd31}), h, c, it, cyc);
      check("R3 hard pattern", 32'(h), 32'(pat));
      check("R3 converged per check rule", 32'(c), 32'(satisfies(pat)));
    end

    // R2: negative small LLRs with zero scaling
    run(1'b1, mk('{16'hFFFF, 8'd3, 5'd31, 8'sd0, 5'd31}), h, c, it, cyc);
    check("R2 negative gives one", 32'(h), 32'hFFFF);
    check("R6 immediate convergence", 32'(it), 1);

    // R9: start during decoding is ignored
    @(negedge clk);
    llr = mk(VECS[0]);
    st_a = 1'b1;
    @(negedge clk);
    st_a = 1'b0; cyc = 0;
    repeat (3) begin @(negedge clk); cyc++; end
    llr = mk(VECS[1]);
    st_a = 1'b1;
    @(negedge clk);
    st_a = 1'b0; cyc++;
    while (!done_a && cyc < 2000) begin @(negedge clk); cyc++; end
    check("R9 result of first block", 32'(hard_a), 32'h0000);
    check("R9 latency unchanged", 32'(cyc), 32'(M + 1));
    @(negedge clk);
    check("R9 no second run", 32'(busy_a), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule